// File: doc/BRIEF.md
# Servo Pulse Generator with Key-Selected Presets

This block drives one hobby-servo command line. A prescaler divides the system clock into a slow one-cycle enable (50 kHz from 50 MHz by default). On each enable a frame counter steps through a fixed number of ticks (1000 by default) and then returns to zero. This gives a 20 ms frame. The output is registered. It is high while the frame counter is below the active duty setpoint and low for the rest of the frame. The pulse width is therefore the setpoint times the tick length.

The setpoint comes from two active-low pushbuttons. They pass through a two-flop synchronizer and are then decoded into one of three travel presets: minimum (1 ms), neutral (1.5 ms) and maximum (2 ms). When no key is pressed the last choice is held. A newly requested setpoint is staged and moves into the active register only at the frame boundary, so a pulse already in progress is never cut short or lengthened.

Top module: `servo_pulse_gen`

## Requirements
- R1: Between two rising edges of `pwm_o`, exactly FRAME_TICKS*CLK_DIV clock cycles pass, because the frame counter advances only once per CLK_DIV clock cycles.
- R2: The frame counter runs 0..FRAME_TICKS-1. On the tick after FRAME_TICKS-1 it returns to 0, even though FRAME_TICKS is not a power of two.
- R3: In each frame `pwm_o` is high for duty*CLK_DIV consecutive clock cycles starting at the frame start, and low for the rest of the frame. The output comes from a register.
- R4: While `rst_ni` is low, `pwm_o` is low and the frame counter is 0. After reset the active duty is the neutral preset PRESET_MID.
- R5: The synchronized key pair `key_n[1:0]` selects the preset: 2'b00 (both pressed) gives PRESET_MIN, 2'b10 (only `key_n[0]` pressed) gives PRESET_MID, and 2'b01 (only `key_n[1]` pressed) gives PRESET_MAX.
- R6: `key_n` equal to 2'b11 (no key pressed) leaves the setpoint at its previous value.
- R7: A new setpoint takes effect only at the next frame start. A pulse already high when the key changes keeps its old width.
- R8: A duty of 0 keeps `pwm_o` low for the whole frame. A duty of FRAME_TICKS or more keeps it high for the whole frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_n | input | 2 | Active-low pushbuttons, asynchronous to the clock |
| pwm_o | output | 1 | Registered servo pulse output |

## Verification
Every internal fault shows up in the pulse widths measured at `pwm_o` within one or two frames. A wrong prescaler or a wrong wrap point changes the frame period. A wrong decode, or a hold that fails, changes the high time of the first frame after the key settles. A setpoint copied into the active register outside the wrap changes the width of the pulse that was in progress when the key moved. A second instance with presets of 0 and above the frame length checks that the comparator saturates to a constant output for whole frames.

// File: rtl/servo_pkg.sv
package servo_pkg;

  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_MID  = 2'd2,
    SEL_MAX  = 2'd3
  } preset_sel_e;

  // Active-low key pair to preset choice; bit 0 is the first key.
  function automatic preset_sel_e decode_keys(input logic [1:0] keys_n);
    case (keys_n)
      2'b00:   decode_keys = SEL_MIN;
      2'b10:   decode_keys = SEL_MID;
      2'b01:   decode_keys = SEL_MAX;
      default: decode_keys = SEL_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/servo_tick_gen.sv
module servo_tick_gen #(
  parameter int CLK_DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    if (pre_q == LAST) pre_d = '0;
    else               pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign tick_o = (pre_q == LAST);
endmodule

// File: rtl/servo_key_sync.sv
module servo_key_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] keys_n_i,
  output logic [WIDTH-1:0] keys_n_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  // Reset to the released level so that no preset is requested.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= keys_n_i;
      sync_q <= meta_q;
    end
  end

  assign keys_n_o = sync_q;
endmodule

// File: rtl/servo_setpoint.sv
module servo_setpoint
  import servo_pkg::*;
#(
  parameter int DUTY_W     = 10,
  parameter int PRESET_MIN = 50,
  parameter int PRESET_MID = 75,
  parameter int PRESET_MAX = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        keys_n_i,
  input  logic              wrap_i,
  output logic [DUTY_W-1:0] duty_o
);
  localparam logic [DUTY_W-1:0] V_MIN = DUTY_W'(PRESET_MIN);
  localparam logic [DUTY_W-1:0] V_MID = DUTY_W'(PRESET_MID);
  localparam logic [DUTY_W-1:0] V_MAX = DUTY_W'(PRESET_MAX);

  preset_sel_e       sel;
  logic [DUTY_W-1:0] pend_q, pend_d;
  logic [DUTY_W-1:0] act_q, act_d;

  always_comb begin
    sel = decode_keys(keys_n_i);
    case (sel)
      SEL_MIN: pend_d = V_MIN;
      SEL_MID: pend_d = V_MID;
      SEL_MAX: pend_d = V_MAX;
      default: pend_d = pend_q;
    endcase
    act_d = wrap_i ? pend_q : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= V_MID;
      act_q  <= V_MID;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign duty_o = act_q;
endmodule

// File: rtl/servo_sawtooth.sv
module servo_sawtooth #(
  parameter int FRAME_TICKS = 1000,
  parameter int CNT_W       = 10,
  parameter int DUTY_W      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o,
  output logic              pwm_o
);
  localparam int CW = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(FRAME_TICKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pwm_q, pwm_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == TOP);
    cnt_d  = cnt_q;
    if (tick_i) begin
      if (at_top) cnt_d = '0;
      else        cnt_d = cnt_q + 1'b1;
    end
    pwm_d = (CW'(cnt_q) < CW'(duty_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & at_top;
  assign pwm_o  = pwm_q;
endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen #(
  parameter int CLK_DIV     = 1000,
  parameter int FRAME_TICKS = 1000,
  parameter int DUTY_W      = 10,
  parameter int PRESET_MIN  = 50,
  parameter int PRESET_MID  = 75,
  parameter int PRESET_MAX  = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] key_n,
  output logic       pwm_o
);
  localparam int CNT_W = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;

  logic              rst_meta_q, rst_sync_n;
  logic              tick_en;
  logic [1:0]        keys_s;
  logic              frame_wrap;
  logic [DUTY_W-1:0] duty_act;
  logic [CNT_W-1:0]  saw_cnt;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  servo_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (tick_en)
  );

  servo_key_sync #(.WIDTH(2)) u_keys (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .keys_n_i (key_n),
    .keys_n_o (keys_s)
  );

  servo_setpoint #(
    .DUTY_W     (DUTY_W),
    .PRESET_MIN (PRESET_MIN),
    .PRESET_MID (PRESET_MID),
    .PRESET_MAX (PRESET_MAX)
  ) u_setp (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .keys_n_i (keys_s),
    .wrap_i   (frame_wrap),
    .duty_o   (duty_act)
  );

  servo_sawtooth #(
    .FRAME_TICKS (FRAME_TICKS),
    .CNT_W       (CNT_W),
    .DUTY_W      (DUTY_W)
  ) u_saw (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_i (tick_en),
    .duty_i (duty_act),
    .cnt_o  (saw_cnt),
    .wrap_o (frame_wrap),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/servo_pulse_chk.sv
module servo_pulse_chk #(
  parameter int CLK_DIV     = 1000,
  parameter int FRAME_TICKS = 1000,
  parameter int CNT_W       = 10,
  parameter int DUTY_W      = 10
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [DUTY_W-1:0] duty,
  input logic              wrap,
  input logic              pwm
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(FRAME_TICKS - 1);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt <= TOP);  // R2

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick && cnt == TOP) |=> (cnt == '0));  // R2

  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick |=> $stable(cnt));  // R1

  AST_DUTY_FRAME: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wrap |=> $stable(duty));  // R7

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt == '0 && duty != '0) |=> pwm);  // R3

  AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_n)
    (duty == '0) |=> !pwm);  // R8

  AST_RESET_LOW: assert property (@(posedge clk_i)
    !rst_n |-> (!pwm && cnt == '0));  // R4

  if (CLK_DIV > 1) begin : g_gap
    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_n)
      tick |=> !tick);  // R1
  end
endmodule

bind servo_pulse_gen servo_pulse_chk #(
  .CLK_DIV     (CLK_DIV),
  .FRAME_TICKS (FRAME_TICKS),
  .CNT_W       (CNT_W),
  .DUTY_W      (DUTY_W)
) u_chk (
  .clk_i (clk_i),
  .rst_n (rst_sync_n),
  .tick  (tick_en),
  .cnt   (saw_cnt),
  .duty  (duty_act),
  .wrap  (frame_wrap),
  .pwm   (pwm_o)
);

// File: tb/tb_servo_pulse_gen.sv
module tb_servo_pulse_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int FRAME = 25;
  localparam int P_MIN = 5;
  localparam int P_MID = 8;
  localparam int P_MAX = 12;
  localparam int PERIOD = FRAME * DIV;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] key_n, key_e_n;
  logic       pwm, pwm_e;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  servo_pulse_gen #(.CLK_DIV(DIV), .FRAME_TICKS(FRAME), .DUTY_W(10),
    .PRESET_MIN(P_MIN), .PRESET_MID(P_MID), .PRESET_MAX(P_MAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .key_n(key_n), .pwm_o(pwm));

  // Presets at the comparator limits: 0 and beyond the frame length.
  servo_pulse_gen #(.CLK_DIV(DIV), .FRAME_TICKS(FRAME), .DUTY_W(10),
    .PRESET_MIN(0), .PRESET_MID(P_MID), .PRESET_MAX(FRAME + 5)) dut_edge (
    .clk_i(clk), .rst_ni(rst_n), .key_n(key_e_n), .pwm_o(pwm_e));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = pwm;
    for (int i = 0; i < 4 * PERIOD; i++) begin
      @(negedge clk);
      if (pwm && !prev) return;
      prev = pwm;
    end
  endtask

  // Called right after a rise was seen; ends on the next rise.
  task automatic frame(output int hi, output int per);
    int lo;
    hi = 1; lo = 0;
    for (int i = 0; i < 4 * PERIOD; i++) begin
      @(negedge clk);
      if (!pwm) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 4 * PERIOD; i++) begin
      @(negedge clk);
      if (pwm) break;
      lo++;
    end
    per = hi + lo;
  endtask

  task automatic select(input logic [1:0] k, input int exp_duty, input string req);
    int hi, per;
    key_n = k;
    repeat (2 * PERIOD) @(negedge clk);
    wait_rise();
    frame(hi, per);
    check({req, " width"}, hi, exp_duty * DIV);
    check("R1 period", per, PERIOD);
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      @(negedge clk);
      if (pwm_e) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, per, n;
    rst_n = 1'b0; key_n = 2'b11; key_e_n = 2'b11;
    repeat (5) @(negedge clk);
    check("R4 output low in reset", int'(pwm), 0);
    rst_n = 1'b1;
    wait_rise();
    frame(hi, per);
    check("R4 neutral after reset", hi, P_MID * DIV);
    check("R1 period after reset", per, PERIOD);

    // Sweep every key code, each hold following a selection.
    select(2'b00, P_MIN, "R5 both keys");
    select(2'b11, P_MIN, "R6 hold min");
    select(2'b10, P_MID, "R5 first key");
    select(2'b11, P_MID, "R6 hold mid");
    select(2'b01, P_MAX, "R5 second key");
    select(2'b11, P_MAX, "R6 hold max");
    select(2'b00, P_MIN, "R5 both keys again");

    // R7: key moves while the min pulse is high.
    wait_rise();
    key_n = 2'b01;
    frame(hi, per);
    check("R7 pulse in progress kept", hi, P_MIN * DIV);
    frame(hi, per);
    check("R7 new width next frame", hi, P_MAX * DIV);
    check("R3 period with new width", per, PERIOD);
    key_n = 2'b11;

    // R8: saturated duties on the edge instance.
    key_e_n = 2'b01;
    repeat (3 * PERIOD) @(negedge clk);
    count_high(n);
    check("R8 duty above frame constant high", n, 3 * PERIOD);
    key_e_n = 2'b00;
    repeat (3 * PERIOD) @(negedge clk);
    count_high(n);
    check("R8 zero duty constant low", n, 0);
    key_e_n = 2'b11;
    count_high(n);
    check("R6 hold zero duty", n, 0);

    // R4: reset mid-run returns to neutral.
    rst_n = 1'b0;
    @(negedge clk);
    check("R4 async clear of output", int'(pwm), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_rise();
    frame(hi, per);
    check("R4 neutral after second reset", hi, P_MID * DIV);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule